// File: doc/BRIEF.md
# Page-Mode DRAM Burst Controller

This block connects a cache-line requester to a DRAM that takes its row and column addresses over one shared, multiplexed address bus. A request names a line address and a direction. The controller opens the line's row once with the row strobe. It then steps through the line's four contiguous columns with the column strobe while the row stays open. Read data goes back one beat at a time with a valid strobe. Write data is pulled one beat at a time with a ready strobe. Every burst follows a fixed 6-3-3-3 clock pattern. A line is always one whole cache block inside a single row, so a burst never crosses a row boundary.

A distributed refresh scheduler runs alongside the burst path. It opens one row at a time with a row-only activation. The row counter advances after each refresh. The pacing is chosen so that every row is refreshed once per retention window. The window is a parameter counted in clock cycles; a real design sets it to between 2 ms and 8 ms worth of cycles. After reset, one full back-to-back refresh pass runs before any request is taken. After that, a refresh that falls due waits for the current burst to finish, and then it wins over any waiting request.

Top module: `pgdram_ctrl`

## Requirements
- R1: While reset is applied and in the first cycle after it, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high, and `req_ready`, `rd_valid` and `wr_ready` are low. The refresh row counter starts at zero, so the first refresh drives row 0.
- R2: Starting in the first cycle after reset, the controller runs ROWS refreshes back to back, on rows 0 to ROWS-1 in order. `req_ready` stays low until that pass has finished.
- R3: During the three row-setup cycles of a burst, `dram_addr` carries the line's row, which is the upper AW bits of `req_line`. During each beat it carries the column, built as {low AW-2 bits of `req_line`, 2-bit beat index}, with the beat index counting up from 0 to 3.
- R4: If a request is accepted at clock edge k, `dram_ras_n` is low from cycle k+1 through cycle k+15. Beat b occupies cycles k+4+3b to k+6+3b. In a beat, `dram_cas_n` is high in the first cycle and low in the other two. So the first word completes at cycle k+6 and each later word 3 cycles after the one before (6-3-3-3).
- R5: In a read burst, `rd_valid` is high only in the last cycle of each beat. In that cycle `rd_data` equals the DRAM word at the beat's row and column, and the beats come in ascending column order.
- R6: In a write burst, `wr_ready` is high only in the first cycle of each beat. The word offered in that cycle is written at that beat's column. `dram_we_n` is low throughout every beat of a write burst and high at all other times.
- R7: After each row activation, whether for a burst or for a refresh, `dram_ras_n` stays high for PRE_CYC (3) cycles. `req_ready` is low during that time.
- R8: A refresh drives `dram_ras_n` low for RFSH_CYC (3) cycles with the refresh row on `dram_addr`, while `dram_cas_n` and `dram_we_n` stay high.
- R9: A refresh falls due in each cycle c (counted from the first cycle after reset) where c mod (RETAIN_CYC/ROWS) equals RETAIN_CYC/ROWS - 1. The refresh row advances by one after each refresh and wraps from ROWS-1 to 0.
- R10: A refresh that falls due during a burst waits until that burst's precharge has ended, and then it starts ahead of any waiting request. `req_ready` is high only when the controller is idle and no refresh is due.
- R11: With the default parameters, refresh activity (activation plus precharge) takes up less than 5% of all cycles after the initial pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronously released inside |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Request accepted at the edge where valid and ready are both high |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_line | input | 2*AW-2 | Cache-line address (row in the upper AW bits) |
| wr_data | input | DW | Write word for the current beat |
| wr_ready | output | 1 | Write word taken this cycle |
| rd_data | output | DW | Read word |
| rd_valid | output | 1 | Read word valid this cycle |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | AW | Multiplexed row/column address |
| dram_wdata | output | DW | Data driven to the DRAM |
| dram_rdata | input | DW | Data returned by the DRAM |

## Verification
Two events can land in the same cycle: the refresh timer can fire in exactly the cycle a request is accepted, and a refresh can fall due while a request is already waiting at an idle controller. Both cases are provoked in two ways. Idle gaps of 0 to 20 cycles are swept between requests, and long runs of back-to-back bursts let the 128-cycle refresh timer drift across every position of the 19-cycle burst. A behavioural per-cycle model decides on its own which operation owns the next row activation and compares every strobe, address and handshake against it. A final check confirms that at least one refresh was actually deferred behind a burst.

// File: rtl/pgdram_pkg.sv
package pgdram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_PRE,
    ST_RFSH
  } seq_state_e;

  localparam int BEATS  = 4;
  localparam int BEAT_W = 2;

endpackage

// File: rtl/pgdram_refresh.sv
module pgdram_refresh #(
  parameter int AW         = 4,
  parameter int RETAIN_CYC = 2048
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rf_start,
  input  logic          rf_done,
  output logic          rf_due,
  output logic [AW-1:0] rf_row,
  output logic          init_busy
);

  localparam int ROWS     = 2 ** AW;
  localparam int INTERVAL = RETAIN_CYC / ROWS;
  localparam int TW       = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

  logic [TW-1:0] tmr_q, tmr_n;
  logic          pend_q, pend_n;
  logic [AW-1:0] row_q, row_n;
  logic          init_q, init_n;
  logic          tick;

  assign tick = (tmr_q == TW'(INTERVAL - 1));

  always_comb begin
    tmr_n  = tick ? '0 : tmr_q + 1'b1;
    pend_n = tick | (pend_q & ~rf_start);
    row_n  = row_q;
    init_n = init_q;
    if (rf_done) begin
      row_n = row_q + 1'b1;
      if (&row_q) begin
        init_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      pend_q <= 1'b0;
      row_q  <= '0;
      init_q <= 1'b1;
    end else begin
      tmr_q  <= tmr_n;
      pend_q <= pend_n;
      if (rf_done) begin
        row_q  <= row_n;
        init_q <= init_n;
      end
    end
  end

  assign rf_due    = pend_q | init_q;
  assign rf_row    = row_q;
  assign init_busy = init_q;

endmodule

// File: rtl/pgdram_seq.sv
module pgdram_seq
  import pgdram_pkg::*;
#(
  parameter int LINE_W   = 6,
  parameter int SETUP_CYC = 3,
  parameter int BEAT_CYC = 3,
  parameter int PRE_CYC  = 3,
  parameter int RFSH_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [LINE_W-1:0] req_line,
  input  logic              rf_due,
  output logic              req_ready,
  output logic              rf_start,
  output logic              rf_done,
  output seq_state_e        state,
  output logic [BEAT_W-1:0] beat,
  output logic [LINE_W-1:0] line,
  output logic              rd_valid,
  output logic              wr_ready,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n
);

  localparam int MAX_A  = (SETUP_CYC > BEAT_CYC) ? SETUP_CYC : BEAT_CYC;
  localparam int MAX_B  = (PRE_CYC > RFSH_CYC) ? PRE_CYC : RFSH_CYC;
  localparam int MAX_PH = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int PH_W   = $clog2(MAX_PH) + 1;

  seq_state_e        st_q, st_n;
  logic [PH_W-1:0]   ph_q, ph_n;
  logic [BEAT_W-1:0] bt_q, bt_n;
  logic [LINE_W-1:0] line_q;
  logic              wr_q;
  logic              accept;

  assign req_ready = (st_q == ST_IDLE) && !rf_due;
  assign accept    = req_ready && req_valid;

  always_comb begin
    st_n     = st_q;
    ph_n     = ph_q;
    bt_n     = bt_q;
    rf_start = 1'b0;
    rf_done  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (rf_due) begin
          st_n     = ST_RFSH;
          ph_n     = '0;
          rf_start = 1'b1;
        end else if (req_valid) begin
          st_n = ST_ROW;
          ph_n = '0;
        end
      end
      ST_ROW: begin
        if (ph_q == PH_W'(SETUP_CYC - 1)) begin
          st_n = ST_COL;
          ph_n = '0;
          bt_n = '0;
        end else begin
          ph_n = ph_q + 1'b1;
        end
      end
      ST_COL: begin
        if (ph_q == PH_W'(BEAT_CYC - 1)) begin
          ph_n = '0;
          if (bt_q == BEAT_W'(BEATS - 1)) begin
            st_n = ST_PRE;
          end else begin
            bt_n = bt_q + 1'b1;
          end
        end else begin
          ph_n = ph_q + 1'b1;
        end
      end
      ST_RFSH: begin
        if (ph_q == PH_W'(RFSH_CYC - 1)) begin
          st_n    = ST_PRE;
          ph_n    = '0;
          rf_done = 1'b1;
        end else begin
          ph_n = ph_q + 1'b1;
        end
      end
      ST_PRE: begin
        if (ph_q == PH_W'(PRE_CYC - 1)) begin
          st_n = ST_IDLE;
          ph_n = '0;
        end else begin
          ph_n = ph_q + 1'b1;
        end
      end
      default: begin
        st_n = ST_IDLE;
        ph_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      ph_q <= '0;
      bt_q <= '0;
    end else begin
      st_q <= st_n;
      ph_q <= ph_n;
      bt_q <= bt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      wr_q   <= 1'b0;
    end else if (accept) begin
      line_q <= req_line;
      wr_q   <= req_write;
    end
  end

  assign state    = st_q;
  assign beat     = bt_q;
  assign line     = line_q;
  assign ras_n    = !((st_q == ST_ROW) || (st_q == ST_COL) || (st_q == ST_RFSH));
  assign cas_n    = !((st_q == ST_COL) && (ph_q != '0));
  assign we_n     = !((st_q == ST_COL) && wr_q);
  assign wr_ready = (st_q == ST_COL) && (ph_q == '0) && wr_q;
  assign rd_valid = (st_q == ST_COL) && (ph_q == PH_W'(BEAT_CYC - 1)) && !wr_q;

endmodule

// File: rtl/pgdram_addr_mux.sv
module pgdram_addr_mux
  import pgdram_pkg::*;
#(
  parameter int AW = 4
) (
  input  seq_state_e        state,
  input  logic [2*AW-3:0]   line,
  input  logic [BEAT_W-1:0] beat,
  input  logic [AW-1:0]     rf_row,
  output logic [AW-1:0]     addr
);

  localparam int LINE_W = 2 * AW - 2;

  always_comb begin
    case (state)
      ST_ROW:  addr = line[LINE_W-1 -: AW];
      ST_COL:  addr = {line[AW-3:0], beat};
      ST_RFSH: addr = rf_row;
      default: addr = '0;
    endcase
  end

endmodule

// File: rtl/pgdram_ctrl.sv
module pgdram_ctrl
  import pgdram_pkg::*;
#(
  parameter int AW         = 4,
  parameter int DW         = 16,
  parameter int RETAIN_CYC = 2048,
  parameter int SETUP_CYC  = 3,
  parameter int BEAT_CYC   = 3,
  parameter int PRE_CYC    = 3,
  parameter int RFSH_CYC   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [2*AW-3:0] req_line,
  input  logic [DW-1:0]   wr_data,
  output logic            wr_ready,
  output logic [DW-1:0]   rd_data,
  output logic            rd_valid,
  output logic            dram_ras_n,
  output logic            dram_cas_n,
  output logic            dram_we_n,
  output logic [AW-1:0]   dram_addr,
  output logic [DW-1:0]   dram_wdata,
  input  logic [DW-1:0]   dram_rdata
);

  localparam int LINE_W = 2 * AW - 2;

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic              rf_start, rf_done, rf_due, init_busy;
  logic [AW-1:0]     rf_row;
  seq_state_e        state;
  logic [BEAT_W-1:0] beat;
  logic [LINE_W-1:0] line;
  logic [DW-1:0]     wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  pgdram_refresh #(
    .AW         (AW),
    .RETAIN_CYC (RETAIN_CYC)
  ) u_refresh (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rf_start  (rf_start),
    .rf_done   (rf_done),
    .rf_due    (rf_due),
    .rf_row    (rf_row),
    .init_busy (init_busy)
  );

  pgdram_seq #(
    .LINE_W    (LINE_W),
    .SETUP_CYC (SETUP_CYC),
    .BEAT_CYC  (BEAT_CYC),
    .PRE_CYC   (PRE_CYC),
    .RFSH_CYC  (RFSH_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_line  (req_line),
    .rf_due    (rf_due),
    .req_ready (req_ready),
    .rf_start  (rf_start),
    .rf_done   (rf_done),
    .state     (state),
    .beat      (beat),
    .line      (line),
    .rd_valid  (rd_valid),
    .wr_ready  (wr_ready),
    .ras_n     (dram_ras_n),
    .cas_n     (dram_cas_n),
    .we_n      (dram_we_n)
  );

  pgdram_addr_mux #(
    .AW (AW)
  ) u_mux (
    .state  (state),
    .line   (line),
    .beat   (beat),
    .rf_row (rf_row),
    .addr   (dram_addr)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wdata_q <= '0;
    end else if (wr_ready) begin
      wdata_q <= wr_data;
    end
  end

  assign dram_wdata = wdata_q;
  assign rd_data    = dram_rdata;

endmodule

// File: rtl/pgdram_ctrl_chk.sv
module pgdram_ctrl_chk #(
  parameter int AW      = 4,
  parameter int PRE_CYC = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic [AW-1:0] addr,
  input logic          req_ready,
  input logic          rd_valid,
  input logic          wr_ready,
  input logic [AW-1:0] rf_row,
  input logic          init_busy
);

  logic [7:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= 8'(PRE_CYC);
    end else if (ras_n) begin
      if (hi_cnt != 8'hFF) hi_cnt <= hi_cnt + 1'b1;
    end else begin
      hi_cnt <= '0;
    end
  end

  p_cas_inside_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);

  p_col_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && $past(!cas_n)) |-> $stable(addr));

  p_precharge_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_cnt >= 8'(PRE_CYC)));

  p_ready_after_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!init_busy && ras_n));

  p_read_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (!cas_n && we_n && !wr_ready));

  p_write_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (cas_n && !ras_n && !we_n));

  p_row_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rf_row) |-> (rf_row == AW'($past(rf_row) + 1'b1)));

endmodule

bind pgdram_ctrl pgdram_ctrl_chk #(
  .AW      (AW),
  .PRE_CYC (PRE_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .ras_n     (dram_ras_n),
  .cas_n     (dram_cas_n),
  .we_n      (dram_we_n),
  .addr      (dram_addr),
  .req_ready (req_ready),
  .rd_valid  (rd_valid),
  .wr_ready  (wr_ready),
  .rf_row    (rf_row),
  .init_busy (init_busy)
);

// File: tb/pgdram_ctrl_bench.sv
module pgdram_ctrl_bench;

  localparam int AW    = 4;
  localparam int DW    = 16;
  localparam int RET   = 2048;
  localparam int ROWS  = 16;
  localparam int INTV  = RET / ROWS;
  localparam int SU    = 3;
  localparam int BC    = 3;
  localparam int PRE   = 3;
  localparam int RF    = 3;
  localparam int NB    = 4;
  localparam int BLAST = SU + NB * BC + PRE - 1;
  localparam int RLAST = RF + PRE - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [2*AW-3:0] req_line = '0;
  logic [DW-1:0] wr_data = '0;
  logic req_ready, wr_ready, rd_valid;
  logic [DW-1:0] rd_data, dram_wdata, dram_rdata;
  logic dram_ras_n, dram_cas_n, dram_we_n;
  logic [AW-1:0] dram_addr;

  pgdram_ctrl #(.AW(AW), .DW(DW), .RETAIN_CYC(RET)) u_pgdram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_line(req_line), .wr_data(wr_data),
    .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_addr(dram_addr), .dram_wdata(dram_wdata), .dram_rdata(dram_rdata)
  );

  initial forever #2 clk = ~clk;

  int nvec = 0;
  int nerr = 0;
  bit model_on = 1'b0;
  bit finished = 1'b0;
  int wseed = 1;

  function automatic logic [DW-1:0] wword(int s, int ln, int b);
    return DW'((s * 499) ^ (ln * 8) ^ b ^ 16'h5A00);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h at t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  endtask

  // simple DRAM array
  logic [DW-1:0] mem [0:255];
  logic [DW-1:0] mem_ref [0:255];
  logic [AW-1:0] open_row = '0;
  logic ras_prev = 1'b1;
  assign dram_rdata = mem[{open_row, dram_addr}];

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = DW'(i * 37 + 16'h1000);
      mem_ref[i] = DW'(i * 37 + 16'h1000);
    end
    forever begin
      @(posedge clk);
      if (!dram_ras_n && ras_prev) open_row = dram_addr;
      if (!dram_ras_n && !dram_cas_n && !dram_we_n) mem[{open_row, dram_addr}] = dram_wdata;
      ras_prev = dram_ras_n;
    end
  end

  // behavioural reference model
  int cyc = 0, op = 0, t0 = 0, mline = 0, rfrow = 0, init_left = ROWS;
  bit mwr = 1'b0, pend = 1'b0;
  int defer_cnt = 0, rf_cycles = 0, post_cycles = 0, wraps = 0;
  int rel, b, p;
  bit due, tick, start_rf;
  logic e_ras, e_cas, e_we, e_rdv, e_wrr, e_rdy;
  logic [AW-1:0] e_addr;
  logic [DW-1:0] e_rd;
  string atag, rtag;

  always @(negedge clk) begin
    if (!model_on) begin
      chk("R1 ras_n in reset", dram_ras_n, 1);
      chk("R1 cas_n in reset", dram_cas_n, 1);
      chk("R1 we_n in reset", dram_we_n, 1);
      chk("R1 req_ready in reset", req_ready, 0);
      chk("R1 rd_valid in reset", rd_valid, 0);
      chk("R1 wr_ready in reset", wr_ready, 0);
    end else begin
      due = (init_left > 0) || pend;
      tick = (cyc % INTV) == (INTV - 1);
      start_rf = 1'b0;
      e_ras = 1; e_cas = 1; e_we = 1; e_rdv = 0; e_wrr = 0; e_rdy = 0;
      e_addr = '0; e_rd = '0; atag = "R3 addr idle"; rtag = "R7 ras_n high";
      if (op == 1) begin
        rel = cyc - t0;
        if (rel < SU) begin
          e_ras = 0; e_addr = AW'(mline >> (AW - 2));
          atag = "R3 row addr"; rtag = "R4 ras_n row setup";
        end else if (rel < SU + NB * BC) begin
          b = (rel - SU) / BC; p = (rel - SU) % BC;
          e_ras = 0; e_cas = (p == 0); e_we = !mwr;
          e_addr = AW'(((mline % 4) * 4) + b);
          e_rdv = !mwr && (p == BC - 1);
          e_wrr = mwr && (p == 0);
          e_rd = mem_ref[mline * 4 + b];
          atag = "R3 col addr"; rtag = "R4 ras_n held";
        end
        if (tick) defer_cnt++;
        if (rel == BLAST) op = 0;
      end else if (op == 2) begin
        rel = cyc - t0;
        if (rel < RF) begin
          e_ras = 0; e_addr = AW'(rfrow);
          atag = (init_left == ROWS) ? "R1 first refresh row" : "R9 refresh row";
          rtag = "R8 refresh ras_n";
        end
        if (init_left == 0) rf_cycles++;
        if (rel == RF - 1) begin
          if (rfrow == ROWS - 1) wraps++;
          rfrow = (rfrow + 1) % ROWS;
          if (init_left > 0) init_left--;
        end
        if (rel == RLAST) op = 0;
      end else begin
        e_rdy = !due;
        if (due) begin
          op = 2; t0 = cyc + 1; start_rf = 1'b1;
        end else if (req_valid) begin
          op = 1; t0 = cyc + 1; mline = int'(req_line); mwr = req_write;
          if (req_write)
            for (int k = 0; k < NB; k++) mem_ref[mline * 4 + k] = wword(wseed, mline, k);
        end
      end
      if (init_left == 0) post_cycles++;
      pend = tick || (pend && !start_rf);

      chk(rtag, dram_ras_n, e_ras);
      chk((op == 2) ? "R8 cas_n" : "R4 cas_n", dram_cas_n, e_cas);
      chk("R6 we_n", dram_we_n, e_we);
      chk(atag, dram_addr, e_addr);
      chk("R5 rd_valid", rd_valid, e_rdv);
      chk("R6 wr_ready", wr_ready, e_wrr);
      chk((init_left > 0) ? "R2 req_ready" : "R10 req_ready", req_ready, e_rdy);
      if (e_rdv) chk("R5 rd_data", rd_data, e_rd);
      cyc++;
    end
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_req(int ln, bit wr);
    req_line = (2*AW-2)'(ln);
    req_write = wr;
    req_valid = 1'b1;
    if (wr) wr_data = wword(wseed, ln, 0);
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (wr) begin
      for (int k = 0; k < NB; k++) begin
        wr_data = wword(wseed, ln, k);
        do @(negedge clk); while (!wr_ready);
        @(posedge clk); #1;
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1 model_on = 1'b1;
    // R2: request waits behind the initial refresh pass
    do_req(5, 0);
    for (int i = 0; i < 8; i++) do_req(i, 1);
    for (int i = 0; i < 8; i++) do_req(i, 0);
    wseed = 2;
    do_req(3, 1); do_req(4, 1); do_req(60, 1); do_req(63, 1);
    do_req(63, 0); do_req(60, 0); do_req(4, 0); do_req(3, 0);
    for (int g = 0; g <= 20; g++) begin
      do_req(g % 64, 0);
      idle(g);
    end
    idle(700);
    wseed = 3;
    for (int i = 0; i < 64; i++) do_req(i, 1);
    for (int i = 0; i < 64; i++) do_req(63 - i, 0);
    for (int i = 0; i < 150; i++) do_req((i * 7) % 64, (i % 5) == 0);
    idle(20);
    // R10: a refresh was deferred behind a burst at least once
    chk("R10 deferral seen", (defer_cnt > 0), 1);
    // R11: refresh duty below 5 percent
    chk("R11 refresh duty", (rf_cycles * 100 < 5 * post_cycles), 1);
    // R9: row counter wrapped after the initial pass
    chk("R9 refresh passes", (wraps >= 3), 1);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    nvec++;
    nerr++;
    $display("FAIL watchdog: run did not complete (actual=hung expected=done)");
    finish_run();
  end

endmodule